// File: doc/BRIEF.md
# I2C Stuck-Bus Timeout Watchdog

This block sits beside the protocol engine of an I2C slave and guards against a bus that hangs. It receives the already-synchronised SCL and SDA levels and single-cycle START and STOP indications from the slave's condition detector. Between a START and the STOP that closes it, the block measures how long each line stays low without a break. When either line stays low for a programmable number of system clock cycles, the block issues a one-cycle reset to the serial state machine. It also stops the slave from driving SDA low, so the slave can no longer hold the bus.

After a timeout the transaction window is closed and a sticky timed-out flag stays set. The slave's request to pull SDA low is masked until the master issues a new START. The limit is a parameter in clock cycles. Its default corresponds to roughly 32.8 ms at a 100 MHz system clock, which is far longer than any low phase of an SCL running at 1 kHz or faster. A test build can set a much smaller limit.

Top module: `i2c_hold_watchdog`

## Requirements
- R1: After reset, `proto_reset` and `timed_out` are 0, no transaction window is open, and `sda_drive_low` equals `slave_sda_pull`.
- R2: A cycle with `start_evt` high opens the transaction window, and a cycle with only `stop_evt` high closes it. When both are high in the same cycle, START takes priority and the window stays open.
- R3: While the window is closed, low levels on SCL or SDA are never timed, however long they last, and never cause a timeout.
- R4: While the window is open, each line has its own run counter that advances on every clock edge at which that line is sampled low. The edge that samples the LIMIT_CYCLES-th consecutive low of either line raises `proto_reset` in the following cycle.
- R5: A line's run counter restarts from zero at every edge where that line is sampled high. Low stretches shorter than LIMIT_CYCLES cycles, such as the phases of an SCL at 1 kHz or faster, never cause a timeout.
- R6: `proto_reset` is high for exactly one cycle per timeout.
- R7: `timed_out` rises together with `proto_reset` and stays high until the next START. A timeout also closes the window, so no further timeout occurs before a new START, even if a line stays low.
- R8: `sda_drive_low` equals `slave_sda_pull` while `timed_out` is 0, and is forced to 0 while `timed_out` is 1.
- R9: A START restarts both run counters. The cycle carrying `start_evt` counts as no low sample, and `proto_reset` is never raised in the cycle after a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| start_evt | input | 1 | One-cycle START (or repeated START) indication |
| stop_evt | input | 1 | One-cycle STOP indication |
| slave_sda_pull | input | 1 | Slave engine requests to pull SDA low |
| sda_drive_low | output | 1 | Gated SDA pull-down enable to the pad |
| proto_reset | output | 1 | One-cycle reset to the serial state machine |
| timed_out | output | 1 | Sticky flag: timeout occurred, cleared by START |

## Verification
The assertions assume that `start_evt` and `stop_evt` are single-cycle pulses already aligned to `clk`. They also assume that the line levels are stable, synchronous samples and need no further metastability filtering. The stimulus changes every input only on the falling clock edge and raises each event for exactly one cycle. It covers idle buses held low, SCL and SDA toggling with low phases just under the limit, a line held low past the limit, and simultaneous STOP and START. A reference model driven by the same inputs is compared against all three outputs after every rising edge.

// File: rtl/i2c_hold_watchdog_pkg.sv
package i2c_hold_watchdog_pkg;
  localparam int unsigned NUM_LINES = 2;
  typedef enum logic [0:0] {LINE_SCL = 1'b0, LINE_SDA = 1'b1} line_e;
  localparam int unsigned DEFAULT_LIMIT = 3_280_000;
endpackage

// File: rtl/xfer_window.sv
module xfer_window (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic fire,
  output logic open_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else if (start_evt) begin
      open_q <= 1'b1;
    end else if (stop_evt || fire) begin
      open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/low_run_counter.sv
module low_run_counter #(
  parameter int unsigned LIMIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic line_low,
  output logic hit
);
  localparam int unsigned CW = $clog2(LIMIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT_CYCLES - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT_CYCLES);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clear || !line_low) begin
      run_q <= '0;
    end else if (run_q != TOP) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign hit = line_low && !clear && (run_q == LAST);
endmodule

// File: rtl/i2c_hold_watchdog.sv
module i2c_hold_watchdog
  import i2c_hold_watchdog_pkg::*;
#(
  parameter int unsigned LIMIT_CYCLES = DEFAULT_LIMIT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic slave_sda_pull,
  output logic sda_drive_low,
  output logic proto_reset,
  output logic timed_out
);
  logic                 xfer_open;
  logic                 fire;
  logic                 clear_runs;
  logic [NUM_LINES-1:0] line_low;
  logic [NUM_LINES-1:0] line_hit;

  assign line_low[LINE_SCL] = ~scl_in;
  assign line_low[LINE_SDA] = ~sda_in;
  assign clear_runs = !xfer_open || start_evt;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    low_run_counter #(.LIMIT_CYCLES(LIMIT_CYCLES)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear_runs),
      .line_low (line_low[g]),
      .hit      (line_hit[g])
    );
  end

  assign fire = |line_hit;

  xfer_window u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .fire      (fire),
    .open_q    (xfer_open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      proto_reset <= 1'b0;
      timed_out   <= 1'b0;
    end else begin
      proto_reset <= fire;
      if (start_evt) begin
        timed_out <= 1'b0;
      end else if (fire) begin
        timed_out <= 1'b1;
      end
    end
  end

  assign sda_drive_low = slave_sda_pull && !timed_out;
endmodule

// File: rtl/i2c_hold_watchdog_checker.sv
module i2c_hold_watchdog_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_in,
  input logic start_evt,
  input logic slave_sda_pull,
  input logic sda_drive_low,
  input logic proto_reset,
  input logic timed_out,
  input logic xfer_open
);
  p_one_cycle_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    proto_reset |=> !proto_reset);

  p_flag_with_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_reset |-> timed_out);

  p_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> !sda_drive_low);

  p_pass_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !timed_out |-> (sda_drive_low == slave_sda_pull));

  p_closed_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_open |=> !proto_reset);

  p_high_lines_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && sda_in) |=> !proto_reset);

  p_start_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!proto_reset && !timed_out && xfer_open));
endmodule

bind i2c_hold_watchdog i2c_hold_watchdog_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .scl_in         (scl_in),
  .sda_in         (sda_in),
  .start_evt      (start_evt),
  .slave_sda_pull (slave_sda_pull),
  .sda_drive_low  (sda_drive_low),
  .proto_reset    (proto_reset),
  .timed_out      (timed_out),
  .xfer_open      (xfer_open)
);

// File: tb/i2c_hold_watchdog_bench.sv
`timescale 1ns/1ps
module i2c_hold_watchdog_bench;
  localparam int LIM = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, st = 1'b0, sp = 1'b0, pull = 1'b0;
  logic drv, prst, tout;

  int checks = 0, fails = 0, pulses = 0;
  int m_open = 0, m_cs = 0, m_cd = 0, m_pulse = 0, m_flag = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_hold_watchdog #(.LIMIT_CYCLES(LIM)) u_i2c_hold_watchdog (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .start_evt(st), .stop_evt(sp), .slave_sda_pull(pull),
    .sda_drive_low(drv), .proto_reset(prst), .timed_out(tout)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_open = 0; m_cs = 0; m_cd = 0; m_pulse = 0; m_flag = 0;
    end else begin
      int fire;
      fire = (m_open && !st && ((!scl && m_cs == LIM-1) || (!sda && m_cd == LIM-1))) ? 1 : 0;
      if (!m_open || st || scl) m_cs = 0; else if (m_cs < LIM) m_cs++;
      if (!m_open || st || sda) m_cd = 0; else if (m_cd < LIM) m_cd++;
      m_pulse = fire;
      if (st) m_flag = 0; else if (fire) m_flag = 1;
      if (st) m_open = 1; else if (sp || fire) m_open = 0;
    end
  end

  // per-cycle comparison, away from both edges
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R4 proto_reset", int'(prst), m_pulse);
      chk("R7 timed_out", int'(tout), m_flag);
      chk("R8 sda_drive_low", int'(drv), (pull && !m_flag) ? 1 : 0);
      if (prst) pulses++;
    end
  end

  task automatic cyc(input logic c, input logic d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); scl = c; sda = d;
    end
  endtask

  task automatic ev(input logic s, input logic p);
    @(negedge clk); st = s; sp = p; scl = 1'b1; sda = 1'b1;
    @(negedge clk); st = 1'b0; sp = 1'b0;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pull = 1'b1;
    @(negedge clk);
    chk("R1 reset proto_reset", int'(prst), 0);
    chk("R1 reset timed_out", int'(tout), 0);
    chk("R1 reset drive follows pull", int'(drv), 1);

    // R3: closed window, lines low a long time
    base = pulses;
    cyc(1'b0, 1'b0, 3*LIM);
    cyc(1'b1, 1'b1, 2);
    chk("R3 no timeout while closed", pulses - base, 0);

    // R5: open, both lines toggle with lows just under the limit
    ev(1'b1, 1'b0);
    base = pulses;
    for (int k = 0; k < 8; k++) begin
      cyc(1'b0, 1'b1, LIM-1);
      cyc(1'b1, 1'b0, LIM-1);
      cyc(1'b1, 1'b1, 1);
    end
    cyc(1'b1, 1'b1, 2);
    chk("R5 short lows never time out", pulses - base, 0);

    // R4/R6/R7/R8: SCL held low past the limit
    base = pulses;
    cyc(1'b0, 1'b1, LIM - 1);
    @(negedge clk);
    chk("R4 no pulse before limit", int'(prst), 0);
    scl = 1'b0;
    @(negedge clk);
    chk("R4 pulse after limit-th low", int'(prst), 1);
    chk("R8 drive released", int'(drv), 0);
    @(negedge clk);
    chk("R6 pulse one cycle", int'(prst), 0);
    cyc(1'b0, 1'b0, 3*LIM);
    chk("R7 single timeout, flag held", pulses - base, 1);
    chk("R7 flag still set", int'(tout), 1);

    // R9: START clears flag, restarts counting
    ev(1'b1, 1'b0);
    chk("R9 start clears flag", int'(tout), 0);
    chk("R8 drive follows pull again", int'(drv), 1);
    base = pulses;
    cyc(1'b1, 1'b0, LIM - 4);
    @(negedge clk); st = 1'b1;
    @(negedge clk); st = 1'b0;
    cyc(1'b1, 1'b0, LIM - 2);
    chk("R9 count restarted by start", pulses - base, 0);
    cyc(1'b1, 1'b0, 3);
    chk("R9 fires after full run from start", pulses - base, 1);

    // R2: STOP with START same cycle keeps window open
    ev(1'b1, 1'b0);
    ev(1'b1, 1'b1);
    base = pulses;
    cyc(1'b1, 1'b0, LIM + 2);
    chk("R2 start beats stop", pulses - base, 1);
    ev(1'b1, 1'b0);
    ev(1'b0, 1'b1);
    base = pulses;
    cyc(1'b0, 1'b1, 2*LIM);
    cyc(1'b1, 1'b1, 2);
    chk("R2 stop closes window", pulses - base, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired (R1..) actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule